// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port

This block is the serial test port of a synchronous memory device. A four-wire serial interface drives it: a test clock, a mode-select line, a serial data input, and a serial data output with its own output enable. A sixteen-state controller follows the mode-select line. The controller steps a 3-bit instruction register and a set of data registers through capture, shift and update phases. The active instruction chooses which data register sits between the serial input and the serial output. It also decides whether the memory's output drivers are forced to high impedance.

There are three data registers. The first is a single-bit bypass stage. The second is a 32-bit identification word built from parameters that give the revision, the organisation and the manufacturer. The third is a boundary chain that captures the pad values presented on an input vector. The chain length comes from the organisation parameter: 51 cells for the 18-bit-wide organisation and 70 cells for the 36-bit-wide one.

The controller states are Reset, Idle, Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, and the matching Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR. Each state's transition depends on the mode-select line, which is called `tms` below:
- Reset goes to Idle on `tms`=0 and stays on 1.
- Idle stays on 0 and goes to Select-DR on 1.
- Select-DR goes to Capture-DR on 0 and to Select-IR on 1.
- Select-IR goes to Capture-IR on 0 and to Reset on 1.
- Capture goes to Shift on 0 and to Exit1 on 1.
- Shift stays on 0 and goes to Exit1 on 1.
- Exit1 goes to Pause on 0 and to Update on 1.
- Pause stays on 0 and goes to Exit2 on 1.
- Exit2 goes back to Shift on 0 and to Update on 1.
- Update goes to Idle on 0 and to Select-DR on 1.

Top module: `mem_scan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is in Reset, the active instruction is IDCODE (code 001), `hiz_force` is 0 and `tdo_oe` is 0.
- R2: Five rising edges of `tck` with `tms` high bring the controller to Reset from any state. The edge after that, taken in Reset, restores IDCODE and clears `hiz_force`.
- R3: In Capture-IR the instruction shift register loads 001. Bit 0 leaves on `tdo` first.
- R4: An instruction shifted into the instruction register changes neither the active instruction nor `hiz_force` until the edge taken in Update-IR.
- R5: IDCODE (001) selects the 32-bit ID register, and Capture-DR loads it. The word is assembled as follows:
  - bits 31:28 hold the revision;
  - bits 27:23 hold the depth code, 01000 for 1M x 18 and 00100 for 512K x 36;
  - bits 22:18 hold the width code, 00011 for x18 and 00111 for x36;
  - bits 17:12 hold the device ID;
  - bits 11:1 hold the manufacturer code;
  - bit 0 is 1.
  
  Bit 0 is shifted out first.
- R6: EXTEST (000) sets `hiz_force`. It selects the boundary chain, and Capture-DR loads `pad_in` into that chain with `pad_in[0]` shifted out first.
- R7: Code 010 (capture with outputs at high impedance) sets `hiz_force` and captures `pad_in` into the boundary chain, which it selects.
- R8: Code 100 (sample) captures `pad_in` into the boundary chain and selects it, with `hiz_force` at 0.
- R9: BYPASS (111) and the reserved codes 011, 101 and 110 select a one-bit register that loads 0 in Capture-DR. `tdo` repeats `tdi` one shift later, and `hiz_force` is 0.
- R10: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR.
- R11: The boundary chain holds exactly 51 cells for x18 and 70 cells for x36. Data shifted in at `tdi` appears at `tdo` that many shifts later.
- R12: Leaving Shift-DR through Exit1-DR, Pause-DR and Exit2-DR and returning to Shift-DR keeps the partly shifted contents of the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pad_in | input | BSR_LEN | Pad values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| hiz_force | output | 1 | Forces the memory output drivers to high impedance |

## Verification
A controller that is in the wrong state shows up within one falling edge: `tdo_oe` rises or falls at a different point than the mode-select sequence predicts. A wrong active instruction shows up on `hiz_force` in the cycle after Update-IR. It also shows up as a shifted stream of the wrong length or content: a one-bit delay where a 51-bit chain was expected, or the pad values where the ID word was expected. Corrupted shift contents appear bit by bit on `tdo`, one falling edge after each shift. A pause that does not preserve them changes the ID word read out across the pause.

// File: rtl/mem_scan_pkg.sv
package mem_scan_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_e;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_EXTEST  = 3'b000,
        OP_IDCODE  = 3'b001,
        OP_SAMPLEZ = 3'b010,
        OP_RSV3    = 3'b011,
        OP_SAMPLE  = 3'b100,
        OP_RSV5    = 3'b101,
        OP_RSV6    = 3'b110,
        OP_BYPASS  = 3'b111
    } scan_op_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_BOUNDARY
    } dr_path_e;

    localparam logic [OP_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import mem_scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       shift_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       shift_dr
);

    tap_state_e nxt;

    always_comb begin
        unique case (state)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   nxt = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: nxt = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: nxt = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: nxt = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   nxt = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: nxt = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: nxt = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: nxt = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    always_comb begin
        in_reset = (state == TS_RESET);
        cap_ir   = (state == TS_CAP_IR);
        shift_ir = (state == TS_SHIFT_IR);
        upd_ir   = (state == TS_UPD_IR);
        cap_dr   = (state == TS_CAP_DR);
        shift_dr = (state == TS_SHIFT_DR);
    end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import mem_scan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            shift,
    input  logic            upd,
    output scan_op_e        op,
    output logic [OP_W-1:0] shreg,
    output dr_path_e        path,
    output logic            hiz
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            shreg <= IR_CAPTURE;
            op    <= OP_IDCODE;
        end else begin
            if (cap)        shreg <= IR_CAPTURE;
            else if (shift) shreg <= {tdi, shreg[OP_W-1:1]};
            if (in_reset)   op <= OP_IDCODE;
            else if (upd)   op <= scan_op_e'(shreg);
        end
    end

    always_comb begin
        unique case (op)
            OP_EXTEST, OP_SAMPLEZ: begin path = PATH_BOUNDARY; hiz = 1'b1; end
            OP_SAMPLE:             begin path = PATH_BOUNDARY; hiz = 1'b0; end
            OP_IDCODE:             begin path = PATH_IDENT;    hiz = 1'b0; end
            default:               begin path = PATH_BYPASS;   hiz = 1'b0; end
        endcase
    end

endmodule

// File: rtl/scan_dr.sv
module scan_dr
    import mem_scan_pkg::*;
#(
    parameter int          BSR_LEN = 51,
    parameter logic [31:0] ID_WORD = 32'h1
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               cap,
    input  logic               shift,
    input  dr_path_e           path,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic               dr_lsb
);

    logic               byp;
    logic [31:0]        idr;
    logic [BSR_LEN-1:0] bsr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp <= 1'b0;
            idr <= ID_WORD;
            bsr <= '0;
        end else begin
            unique case (path)
                PATH_IDENT: begin
                    if (cap)        idr <= ID_WORD;
                    else if (shift) idr <= {tdi, idr[31:1]};
                end
                PATH_BOUNDARY: begin
                    if (cap)        bsr <= pad_in;
                    else if (shift) bsr <= {tdi, bsr[BSR_LEN-1:1]};
                end
                default: begin
                    if (cap)        byp <= 1'b0;
                    else if (shift) byp <= tdi;
                end
            endcase
        end
    end

    always_comb begin
        unique case (path)
            PATH_IDENT:    dr_lsb = idr[0];
            PATH_BOUNDARY: dr_lsb = bsr[0];
            default:       dr_lsb = byp;
        endcase
    end

endmodule

// File: rtl/mem_scan_tap.sv
module mem_scan_tap
    import mem_scan_pkg::*;
#(
    parameter bit          WIDE_ORG  = 1'b0,
    parameter logic [3:0]  REVISION  = 4'h0,
    parameter logic [5:0]  DEVICE_ID = 6'h00,
    parameter logic [10:0] MFR_CODE  = 11'b00011100100,
    localparam int         BSR_LEN   = WIDE_ORG ? 70 : 51
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               hiz_force
);

    localparam logic [4:0]  DEPTH_CODE = WIDE_ORG ? 5'b00100 : 5'b01000;
    localparam logic [4:0]  WIDTH_CODE = WIDE_ORG ? 5'b00111 : 5'b00011;
    localparam logic [31:0] ID_WORD    = {REVISION, DEPTH_CODE, WIDTH_CODE,
                                          DEVICE_ID, MFR_CODE, 1'b1};

    tap_state_e      state;
    logic            in_reset, cap_ir, shift_ir, upd_ir, cap_dr, shift_dr;
    scan_op_e        op;
    logic [OP_W-1:0] ir_sh;
    dr_path_e        path;
    logic            dr_lsb;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_ir(cap_ir), .shift_ir(shift_ir),
        .upd_ir(upd_ir), .cap_dr(cap_dr), .shift_dr(shift_dr)
    );

    scan_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap(cap_ir), .shift(shift_ir), .upd(upd_ir),
        .op(op), .shreg(ir_sh), .path(path), .hiz(hiz_force)
    );

    scan_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .cap(cap_dr),
        .shift(shift_dr), .path(path), .pad_in(pad_in), .dr_lsb(dr_lsb)
    );

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shift_ir | shift_dr;
            if (shift_ir)      tdo <= ir_sh[0];
            else if (shift_dr) tdo <= dr_lsb;
        end
    end

endmodule

// File: rtl/mem_scan_tap_chk.sv
module mem_scan_tap_chk
    import mem_scan_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_e      state,
    input scan_op_e        op,
    input logic [OP_W-1:0] ir_sh,
    input logic            hiz_force,
    input logic            tdo_oe
);

    logic [2:0] ones;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        ones <= '0;
        else if (!tms)      ones <= '0;
        else if (ones != 3'd5) ones <= ones + 3'd1;
    end

    p_tms_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones == 3'd5) |-> (state == TS_RESET));

    p_hiz_release_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_RESET) |=> !hiz_force);

    p_capture_ir_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_CAP_IR) |=> (ir_sh == 3'b001));

    p_op_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(op));

    p_oe_window_r10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (state == TS_SHIFT_DR || state == TS_SHIFT_IR));

endmodule

bind mem_scan_tap mem_scan_tap_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .op(op),
    .ir_sh(ir_sh), .hiz_force(hiz_force), .tdo_oe(tdo_oe)
);

// File: tb/mem_scan_tap_test.sv
module mem_scan_tap_test;

    localparam int BSR_LEN = 51;
    localparam int VW      = 96;
    localparam logic [31:0] EXP_ID = {4'h0, 5'b01000, 5'b00011, 6'h00, 11'b00011100100, 1'b1};
    // code[5:3], expected hiz[2], register kind[1:0]: 0 bypass, 1 id, 2 boundary
    localparam logic [5:0] TBL [8] = '{
        {3'b000, 1'b1, 2'd2}, {3'b001, 1'b0, 2'd1}, {3'b010, 1'b1, 2'd2}, {3'b011, 1'b0, 2'd0},
        {3'b100, 1'b0, 2'd2}, {3'b101, 1'b0, 2'd0}, {3'b110, 1'b0, 2'd0}, {3'b111, 1'b0, 2'd0}
    };

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [BSR_LEN-1:0] pad_in = '0;
    logic tdo, tdo_oe, hiz_force;
    logic oe_now;
    int n_run = 0, n_fail = 0, edge_err = 0;

    mem_scan_tap uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pad_in(pad_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .hiz_force(hiz_force)
    );

    always #5 tck = ~tck;

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic seen);
        @(negedge tck); #2;
        seen = tdo; oe_now = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck); #1;
        if (tdo !== seen) edge_err++;
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] irout);
        logic s;
        step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int i = 0; i < 3; i++) step(i == 2, code[i], irout[i]);
        step(1, 0, s); step(0, 0, s);
    endtask

    task automatic scan_dr(input int n, input logic [VW-1:0] din, output logic [VW-1:0] dout);
        logic s;
        dout = '0;
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i], dout[i]);
        step(1, 0, s); step(0, 0, s);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VW-1:0] din, dout, exp;
        logic [2:0] irout;
        logic s;
        string tag;
        int n;

        // R1: reset state
        #23;
        chk("R1 hiz in reset", VW'(hiz_force), VW'(0));
        chk("R1 oe in reset", VW'(tdo_oe), VW'(0));
        trst_n = 1'b1;
        step(0, 0, s);
        scan_dr(32, '0, dout);
        chk("R1 IDCODE after reset", dout, VW'(EXP_ID));

        // Table: every instruction code
        for (int k = 0; k < 8; k++) begin
            pad_in = BSR_LEN'({32'hC3A5_5A3C ^ k, 32'h1357_9BDF + k});
            din    = VW'(64'h9E37_79B9_7F4A_7C15 >> k);
            load_ir(TBL[k][5:3], irout);
            if (k == 0) chk("R3 capture-IR pattern", VW'(irout), VW'(3'b001));
            case (TBL[k][5:3])
                3'b000:  tag = "R6";
                3'b001:  tag = "R5";
                3'b010:  tag = "R7";
                3'b100:  tag = "R8";
                default: tag = "R9";
            endcase
            chk({tag, " hiz"}, VW'(hiz_force), VW'(TBL[k][2]));
            if (TBL[k][1:0] == 2'd2) begin
                n = BSR_LEN + 4;
                exp = '0;
                for (int i = 0; i < n; i++) exp[i] = (i < BSR_LEN) ? pad_in[i] : din[i - BSR_LEN];
                scan_dr(n, din, dout);
                chk({tag, " boundary capture"}, dout & ((VW'(1) << BSR_LEN) - 1), exp & ((VW'(1) << BSR_LEN) - 1));
                chk({tag, " R11 chain length"}, dout >> BSR_LEN, exp >> BSR_LEN);
            end else if (TBL[k][1:0] == 2'd1) begin
                scan_dr(32, din, dout);
                chk({tag, " id word"}, dout, VW'(EXP_ID));
            end else begin
                scan_dr(8, din, dout);
                chk({tag, " bypass delay"}, dout, VW'({din[6:0], 1'b0}));
            end
        end

        // R4: instruction applies only at Update-IR (active is BYPASS here)
        step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int i = 0; i < 3; i++) step(i == 2, 1'b0, s);
        #1; chk("R4 hiz in Exit1-IR", VW'(hiz_force), VW'(0));
        step(1, 0, s);
        #1; chk("R4 hiz in Update-IR", VW'(hiz_force), VW'(0));
        step(0, 0, s);
        #1; chk("R4 hiz after update", VW'(hiz_force), VW'(1));

        // R10: output enable window
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        step(0, 0, s);
        chk("R10 oe in Shift-DR", VW'(oe_now), VW'(1));

        // R2: five TMS-high edges from Shift-DR
        for (int i = 0; i < 5; i++) step(1, 0, s);
        step(1, 0, s);
        chk("R10 oe outside shift", VW'(oe_now), VW'(0));
        #1; chk("R2 hiz released", VW'(hiz_force), VW'(0));
        step(0, 0, s);
        scan_dr(32, '0, dout);
        chk("R2 IDCODE restored", dout, VW'(EXP_ID));

        // R12: pause in the middle of a shift
        dout = '0;
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int i = 0; i < 10; i++) step(i == 9, 1'b0, dout[i]);
        step(0, 0, s); step(0, 0, s); step(1, 0, s); step(0, 0, s);
        for (int i = 10; i < 32; i++) step(i == 31, 1'b0, dout[i]);
        step(1, 0, s); step(0, 0, s);
        chk("R12 pause keeps contents", dout, VW'(EXP_ID));

        chk("R10 tdo stable at rising edge", VW'(edge_err), VW'(0));
        finish_run();
    end

endmodule